// File: doc/BRIEF.md
# Byte-Wide ALU with Magnitude-Compare Status

This block is the arithmetic and logic unit of a small 8-bit processor. Each cycle the surrounding sequencer presents a 4-bit operation code, the current value of the destination register (operand A) and a second operand that is either a register or an immediate (operand B). When `issue` is high the operation executes. The block returns the result and a destination write strobe in the same cycle without any register in the path. The status flags are updated at the next rising clock edge.

The block holds the four status flags itself: a carry/borrow bit and three magnitude flags (less, equal, greater). The carry bit is read back by the add-with-carry and subtract-with-borrow operations, so multi-byte arithmetic is built from chained operations. The compare operation changes only the magnitude flags and never writes the destination. The logic operations are NAND and OR. Operation codes 8 to 15 belong to other units and leave this block idle.

Top module: `alu8`

## Requirements
- R1: Opcode 0x0 gives result = (A + B) mod 256 with `writeEn` high, and the carry flag becomes 1 exactly when A + B > 255.
- R2: Opcode 0x1 gives result = (A − B) mod 256 with `writeEn` high, and the carry flag becomes 1 exactly when A < B (borrow).
- R3: Opcode 0x2 gives result = (A + B + C) mod 256, where C is the stored carry flag, and carry becomes 1 exactly when A + B + C > 255.
- R4: Opcode 0x3 gives result = (A − B − C) mod 256, and carry becomes 1 exactly when A < B + C.
- R5: Opcode 0x4 gives the bitwise NAND of A and B, and opcode 0x5 gives the bitwise OR. Both assert `writeEn` and leave the carry flag unchanged.
- R6: Opcode 0x7 gives result = B with `writeEn` high and leaves the carry flag unchanged.
- R7: Opcode 0x6 keeps `writeEn` low, compares A and B as unsigned bytes, and sets exactly one of less (A<B), equal (A=B) or greater (A>B). The carry flag is unchanged.
- R8: Opcodes 0x8 through 0xF keep `writeEn` low and leave all four flags unchanged.
- R9: With `issue` low, `writeEn` is low and no flag changes at the clock edge.
- R10: While `rstN` is low, all four flags are cleared to 0.
- R11: Opcodes 0x0–0x5 and 0x7 leave the less, equal and greater flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Execute the presented operation this cycle |
| opcode | input | 4 | Operation code |
| opA | input | 8 | Destination register value (first operand) |
| opB | input | 8 | Register or immediate value (second operand) |
| result | output | 8 | Combinational operation result |
| writeEn | output | 1 | Destination register write strobe |
| carryFlag | output | 1 | Stored carry / borrow flag |
| lessFlag | output | 1 | Stored A<B flag |
| equalFlag | output | 1 | Stored A=B flag |
| greaterFlag | output | 1 | Stored A>B flag |

## Verification
Several operand patterns are applied. Extremes such as 0x00, 0xFF, 0x7F and 0x80 placed against each other check the carry and borrow boundaries, where an off-by-one in the carry-in polarity shows up. Equal operand pairs separate the equal flag from less and greater. Back-to-back add-with-carry and subtract-with-borrow runs that follow a carry-producing operation show whether the stored carry is actually consumed. Random operands mixed with idle cycles and opcodes 8–15 separate "flags held" from "flags recomputed".

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int OPC_W  = 4;

  typedef enum logic [1:0] {
    RES_ARITH = 2'd0,
    RES_NAND  = 2'd1,
    RES_OR    = 2'd2,
    RES_PASS  = 2'd3
  } resSel_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic    wrDst;
    logic    updCarry;
    logic    updCmp;
    logic    subtract;
    logic    useCarry;
    resSel_e resSel;
  } aluCtrl_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
#(
  parameter int OPC_WIDTH = OPC_W
) (
  input  logic                 issue,
  input  logic [OPC_WIDTH-1:0] opcode,
  output aluCtrl_t             ctrl
);
  localparam int OPC_LIMIT = 8;

  always_comb begin
    ctrl = '{wrDst: 1'b0, updCarry: 1'b0, updCmp: 1'b0,
             subtract: 1'b0, useCarry: 1'b0, resSel: RES_PASS};
    if (issue && (int'(opcode) < OPC_LIMIT)) begin
      case (opcode[2:0])
        3'd0: begin ctrl.wrDst = 1'b1; ctrl.updCarry = 1'b1; ctrl.resSel = RES_ARITH; end
        3'd1: begin ctrl.wrDst = 1'b1; ctrl.updCarry = 1'b1; ctrl.resSel = RES_ARITH;
                    ctrl.subtract = 1'b1; end
        3'd2: begin ctrl.wrDst = 1'b1; ctrl.updCarry = 1'b1; ctrl.resSel = RES_ARITH;
                    ctrl.useCarry = 1'b1; end
        3'd3: begin ctrl.wrDst = 1'b1; ctrl.updCarry = 1'b1; ctrl.resSel = RES_ARITH;
                    ctrl.subtract = 1'b1; ctrl.useCarry = 1'b1; end
        3'd4: begin ctrl.wrDst = 1'b1; ctrl.resSel = RES_NAND; end
        3'd5: begin ctrl.wrDst = 1'b1; ctrl.resSel = RES_OR; end
        3'd6: begin ctrl.updCmp = 1'b1; end
        default: begin ctrl.wrDst = 1'b1; ctrl.resSel = RES_PASS; end
      endcase
    end
  end
endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluCtrl_t         ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             writeEn,
  output logic             carryFlag,
  output logic             lessFlag,
  output logic             equalFlag,
  output logic             greaterFlag
);
  localparam int EXT_W = WIDTH + 1;

  logic             carryQ, lessQ, equalQ, greaterQ;
  logic [WIDTH-1:0] bOperand;
  logic             carryIn, carryGate;
  logic [EXT_W-1:0] sumExt;
  logic             carryNext;

  assign carryGate = ctrl.useCarry & carryQ;
  assign carryIn   = ctrl.subtract ? ~carryGate : carryGate;
  assign bOperand  = ctrl.subtract ? ~opB : opB;
  assign sumExt    = {1'b0, opA} + {1'b0, bOperand} + {{WIDTH{1'b0}}, carryIn};
  // adder carry-out means "no borrow" when subtracting
  assign carryNext = ctrl.subtract ? ~sumExt[WIDTH] : sumExt[WIDTH];

  always_comb begin
    case (ctrl.resSel)
      RES_ARITH: result = sumExt[WIDTH-1:0];
      RES_NAND:  result = ~(opA & opB);
      RES_OR:    result = opA | opB;
      default:   result = opB;
    endcase
  end

  assign writeEn = ctrl.wrDst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ   <= 1'b0;
      lessQ    <= 1'b0;
      equalQ   <= 1'b0;
      greaterQ <= 1'b0;
    end else begin
      if (ctrl.updCarry) carryQ <= carryNext;
      if (ctrl.updCmp) begin
        lessQ    <= opA < opB;
        equalQ   <= opA == opB;
        greaterQ <= opA > opB;
      end
    end
  end

  assign carryFlag   = carryQ;
  assign lessFlag    = lessQ;
  assign equalFlag   = equalQ;
  assign greaterFlag = greaterQ;
endmodule

// File: rtl/alu8.sv
module alu8
  import alu8_pkg::*;
#(
  parameter int WIDTH     = DATA_W,
  parameter int OPC_WIDTH = OPC_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issue,
  input  logic [OPC_WIDTH-1:0] opcode,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  output logic [WIDTH-1:0]     result,
  output logic                 writeEn,
  output logic                 carryFlag,
  output logic                 lessFlag,
  output logic                 equalFlag,
  output logic                 greaterFlag
);
  aluCtrl_t ctrl;

  alu8_ctrl #(.OPC_WIDTH(OPC_WIDTH)) uCtrl (
    .issue  (issue),
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  alu8_dp #(.WIDTH(WIDTH)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .opA         (opA),
    .opB         (opB),
    .result      (result),
    .writeEn     (writeEn),
    .carryFlag   (carryFlag),
    .lessFlag    (lessFlag),
    .equalFlag   (equalFlag),
    .greaterFlag (greaterFlag)
  );
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
  parameter int WIDTH     = 8,
  parameter int OPC_WIDTH = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 issue,
  input logic [OPC_WIDTH-1:0] opcode,
  input logic [WIDTH-1:0]     opA,
  input logic [WIDTH-1:0]     opB,
  input logic [WIDTH-1:0]     result,
  input logic                 writeEn,
  input logic                 carryFlag,
  input logic                 lessFlag,
  input logic                 equalFlag,
  input logic                 greaterFlag
);
  logic isCmp, isHigh, keepsCarry;
  assign isCmp      = issue && (int'(opcode) == 6);
  assign isHigh     = issue && (int'(opcode) >= 8);
  assign keepsCarry = issue && (int'(opcode) == 4 || int'(opcode) == 5 || int'(opcode) == 7);

  p_cmp_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    isCmp |=> $countones({lessFlag, equalFlag, greaterFlag}) == 1);

  p_cmp_nowrite_r7: assert property (@(posedge clk) disable iff (!rstN)
    isCmp |-> !writeEn);

  p_high_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    isHigh |=> $stable({carryFlag, lessFlag, equalFlag, greaterFlag}));

  p_high_nowrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    isHigh |-> !writeEn);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !issue |=> $stable({carryFlag, lessFlag, equalFlag, greaterFlag}));

  p_idle_nowrite_r9: assert property (@(posedge clk) disable iff (!rstN)
    !issue |-> !writeEn);

  p_logic_carry_r5: assert property (@(posedge clk) disable iff (!rstN)
    keepsCarry |=> $stable(carryFlag));

  p_move_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    (issue && int'(opcode) == 7) |-> (result == opB && writeEn));
endmodule

bind alu8 alu8_checker #(.WIDTH(WIDTH), .OPC_WIDTH(OPC_WIDTH)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .issue       (issue),
  .opcode      (opcode),
  .opA         (opA),
  .opB         (opB),
  .result      (result),
  .writeEn     (writeEn),
  .carryFlag   (carryFlag),
  .lessFlag    (lessFlag),
  .equalFlag   (equalFlag),
  .greaterFlag (greaterFlag)
);

// File: tb/sim_alu8.sv
module sim_alu8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       issue = 1'b0;
  logic [3:0] opcode = '0;
  logic [7:0] opA = '0, opB = '0;
  logic [7:0] result;
  logic       writeEn, carryFlag, lessFlag, equalFlag, greaterFlag;

  int nChecks = 0, nFails = 0;
  int mC = 0, mL = 0, mE = 0, mG = 0;
  string flagTag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8 u0 (.clk(clk), .rstN(rstN), .issue(issue), .opcode(opcode), .opA(opA), .opB(opB),
           .result(result), .writeEn(writeEn), .carryFlag(carryFlag), .lessFlag(lessFlag),
           .equalFlag(equalFlag), .greaterFlag(greaterFlag));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tagOf(input bit iss, input int op);
    if (!iss) return "R9";
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6: return "R7";
      7: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic checkFlags();
    check(carryFlag == mC[0], flagTag, "carry", carryFlag, mC);
    check({lessFlag, equalFlag, greaterFlag} == {mL[0], mE[0], mG[0]},
          (flagTag == "R1" || flagTag == "R2" || flagTag == "R3" || flagTag == "R4" ||
           flagTag == "R5" || flagTag == "R6") ? "R11" : flagTag,
          "LEG", {lessFlag, equalFlag, greaterFlag}, {mL[0], mE[0], mG[0]});
  endtask

  // one vector: driven after a falling edge, checked before the rising edge
  task automatic apply(input bit iss, input int op, input int a, input int b);
    int expRes, expWe, t, nc, nl, ne, ng;
    string tag;
    @(negedge clk);
    checkFlags();
    issue = iss; opcode = 4'(op); opA = 8'(a); opB = 8'(b);
    tag = tagOf(iss, op);
    nc = mC; nl = mL; ne = mE; ng = mG;
    expRes = -1; expWe = 0;
    if (iss) begin
      case (op)
        0: begin t = a + b;      expRes = t & 255; nc = (t > 255); expWe = 1; end
        1: begin t = a - b;      expRes = t & 255; nc = (t < 0);   expWe = 1; end
        2: begin t = a + b + mC; expRes = t & 255; nc = (t > 255); expWe = 1; end
        3: begin t = a - b - mC; expRes = t & 255; nc = (t < 0);   expWe = 1; end
        4: begin expRes = (~(a & b)) & 255; expWe = 1; end
        5: begin expRes = (a | b) & 255;    expWe = 1; end
        6: begin nl = (a < b); ne = (a == b); ng = (a > b); end
        7: begin expRes = b; expWe = 1; end
        default: ;
      endcase
    end
    #1;
    check(writeEn == expWe[0], tag, "writeEn", writeEn, expWe);
    if (expRes >= 0) check(result == 8'(expRes), tag, "result", result, expRes);
    @(posedge clk);
    mC = nc; mL = nl; mE = ne; mG = ng;
    flagTag = tag;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int edges[6] = '{0, 1, 127, 128, 254, 255};
    repeat (3) @(negedge clk);
    // R10: flags clear in reset
    check({carryFlag, lessFlag, equalFlag, greaterFlag} == 4'b0, "R10", "reset flags",
          {carryFlag, lessFlag, equalFlag, greaterFlag}, 0);
    rstN = 1'b1;
    // edge operands across every defined opcode
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(1'b1, op, edges[i], edges[j]);
    // carry chains: set carry, then adc/sbb
    apply(1'b1, 0, 255, 1);   apply(1'b1, 2, 0, 0);   apply(1'b1, 2, 254, 0);
    apply(1'b1, 1, 0, 1);     apply(1'b1, 3, 5, 5);   apply(1'b1, 3, 0, 255);
    // compare then logic ops: LEG must hold
    apply(1'b1, 6, 10, 10);   apply(1'b1, 4, 3, 5);   apply(1'b1, 5, 3, 5);
    apply(1'b1, 0, 200, 100); apply(1'b1, 7, 0, 9);
    // high opcodes and idle cycles after setting flags
    apply(1'b1, 6, 1, 2);
    for (int op = 8; op < 16; op++) apply(1'b1, op, 255, 255);
    apply(1'b0, 0, 255, 255); apply(1'b0, 6, 5, 5);
    // random mix
    for (int k = 0; k < 3000; k++)
      apply(($urandom_range(9) != 0), $urandom_range(15), $urandom_range(255), $urandom_range(255));
    @(negedge clk);
    checkFlags();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule